// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This unit turns the operand fields of a memory reference into a 32-bit effective address. It adds an optional base register value, an optional index register value multiplied by a power-of-two scale, and a sign-extended displacement of 1, 2 or 4 bytes. The caller presents all fields with a valid strobe. One clock later the unit returns the address together with a flag that marks an operand combination as illegal.

Register file reads and the memory access are outside the unit. The caller supplies register values and a register ID for the index, and the unit only rejects the stack pointer (ID 4) in the index position. The sum wraps modulo 2^32 and there is no overflow indication.

Top module: `sag_top`

## Requirements
- R1: When `inValid` is sampled high, the next cycle's `addr` equals base + index × scale + displacement, where each term comes from the rules R2 to R5.
- R2: `scaleCode` value k (0, 1, 2, 3) multiplies the index by 2^k, giving scale 1, 2, 4 or 8.
- R3: `dispSize` selects the displacement: 0 means no displacement (zero), 1 means byte `dispBytes[7:0]` sign-extended, 2 means the little-endian halfword `dispBytes[15:0]` sign-extended, and 3 means all four bytes `dispBytes[31:0]`.
- R4: With `baseEn` low, the base term is zero whatever `baseVal` holds.
- R5: With `idxEn` low, the index term is zero, and `idxId` and `idxVal` have no effect. This includes ID 4, which then does not raise `illegal`.
- R6: With `idxEn` high and `idxId` equal to 4 (the stack pointer), the next cycle shows `illegal` = 1 and `addr` = 0. Any other ID gives `illegal` = 0.
- R7: The addition wraps modulo 2^32.
- R8: `outValid` is `inValid` delayed by exactly one cycle. While `inValid` is low, `addr` and `illegal` hold their last values.
- R9: While `rst_n` is low, `outValid`, `illegal` and `addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operand fields valid this cycle |
| baseEn | input | 1 | Base register present |
| baseVal | input | 32 | Base register value |
| idxEn | input | 1 | Index register present |
| idxId | input | 4 | Index register ID |
| idxVal | input | 32 | Index register value |
| scaleCode | input | 2 | Log2 of the scale factor |
| dispBytes | input | 32 | Displacement bytes, little-endian |
| dispSize | input | 2 | Displacement size code |
| outValid | output | 1 | Address valid |
| addr | output | 32 | Effective address |
| illegal | output | 1 | Stack pointer used as index |

## Verification
The bench sweeps every combination of scale code, displacement size, base present, index present and all eight register IDs. It repeats the sweep over three value sets:
- Small positive values show whether each term lands in the sum.
- Values with the sign bit set in each displacement byte expose sign-extension and byte-order mistakes.
- Large values that overflow the sum expose truncation errors.

Directed cases follow. They reproduce the worked address examples, show that ID 4 is harmless without an index, and hold the inputs idle while the operands change to confirm the outputs do not move.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_B1   = 2'd1,
    DISP_B2   = 2'd2,
    DISP_B4   = 2'd3
  } dispSel_e;

  typedef struct packed {
    logic     load;
    logic     useBase;
    logic     useIdx;
    logic     zeroOut;
    logic [1:0] shamt;
    dispSel_e dispSel;
  } sagStrobe_t;

endpackage

// File: rtl/sag_ctrl.sv
module sag_ctrl
  import sag_pkg::*;
#(
  parameter int REG_ID_W = 4,
  parameter int SP_ID    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic                baseEn,
  input  logic                idxEn,
  input  logic [REG_ID_W-1:0] idxId,
  input  logic [1:0]          scaleCode,
  input  logic [1:0]          dispSize,
  output sagStrobe_t          strobe,
  output logic                outValid,
  output logic                illegal
);

  localparam logic [REG_ID_W-1:0] SpCode = REG_ID_W'(SP_ID);

  logic spAsIndex;

  always_comb begin
    spAsIndex       = idxEn && (idxId == SpCode);
    strobe.load     = inValid;
    strobe.useBase  = baseEn;
    strobe.useIdx   = idxEn;
    strobe.zeroOut  = spAsIndex;
    strobe.shamt    = scaleCode;
    strobe.dispSel  = dispSel_e'(dispSize);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) illegal <= spAsIndex;
    end
  end

endmodule

// File: rtl/sag_datapath.sv
module sag_datapath
  import sag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sagStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [DISP_W-1:0] dispBytes,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] dispB1, dispB2, dispB4;
  logic [ADDR_W-1:0] dispExt, baseTerm, idxTerm, sum;

  assign dispB1 = {{(ADDR_W-8){dispBytes[7]}}, dispBytes[7:0]};
  assign dispB2 = {{(ADDR_W-16){dispBytes[15]}}, dispBytes[15:0]};

  generate
    if (ADDR_W > DISP_W) begin : g_wide
      assign dispB4 = {{(ADDR_W-DISP_W){dispBytes[DISP_W-1]}}, dispBytes};
    end else begin : g_equal
      assign dispB4 = dispBytes[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (strobe.dispSel)
      DISP_B1: dispExt = dispB1;
      DISP_B2: dispExt = dispB2;
      DISP_B4: dispExt = dispB4;
      default: dispExt = '0;
    endcase
    baseTerm = strobe.useBase ? baseVal : '0;
    idxTerm  = strobe.useIdx ? (idxVal << strobe.shamt) : '0;
    sum      = baseTerm + idxTerm + dispExt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (strobe.load) addr <= strobe.zeroOut ? '0 : sum;
  end

endmodule

// File: rtl/sag_top.sv
module sag_top
  import sag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 32,
  parameter int REG_ID_W = 4,
  parameter int SP_ID    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic                baseEn,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic                idxEn,
  input  logic [REG_ID_W-1:0] idxId,
  input  logic [ADDR_W-1:0]   idxVal,
  input  logic [1:0]          scaleCode,
  input  logic [DISP_W-1:0]   dispBytes,
  input  logic [1:0]          dispSize,
  output logic                outValid,
  output logic [ADDR_W-1:0]   addr,
  output logic                illegal
);

  sagStrobe_t strobe;

  sag_ctrl #(.REG_ID_W(REG_ID_W), .SP_ID(SP_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .baseEn(baseEn),
    .idxEn(idxEn), .idxId(idxId), .scaleCode(scaleCode),
    .dispSize(dispSize), .strobe(strobe), .outValid(outValid),
    .illegal(illegal)
  );

  sag_datapath #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .baseVal(baseVal),
    .idxVal(idxVal), .dispBytes(dispBytes), .addr(addr)
  );

endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int ADDR_W   = 32,
  parameter int REG_ID_W = 4,
  parameter int SP_ID    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inValid,
  input logic                idxEn,
  input logic [REG_ID_W-1:0] idxId,
  input logic                outValid,
  input logic [ADDR_W-1:0]   addr,
  input logic                illegal
);

  localparam logic [REG_ID_W-1:0] SpCode = REG_ID_W'(SP_ID);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);  // R8
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);  // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(addr) && $stable(illegal)));  // R8
  AST_SP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && idxEn && idxId == SpCode) |=> illegal);  // R6
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (addr == '0));  // R6
  AST_NO_INDEX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !idxEn) |=> !illegal);  // R5

endmodule

bind sag_top sag_checker #(.ADDR_W(ADDR_W), .REG_ID_W(REG_ID_W), .SP_ID(SP_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .idxEn(idxEn), .idxId(idxId),
  .outValid(outValid), .addr(addr), .illegal(illegal)
);

// File: tb/sag_top_bench.sv
`timescale 1ns/1ps
module sag_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        baseEn = 1'b0;
  logic [31:0] baseVal = '0;
  logic        idxEn = 1'b0;
  logic [3:0]  idxId = '0;
  logic [31:0] idxVal = '0;
  logic [1:0]  scaleCode = '0;
  logic [31:0] dispBytes = '0;
  logic [1:0]  dispSize = '0;
  logic        outValid;
  logic [31:0] addr;
  logic        illegal;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sag_top u_sag_top (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .baseEn(baseEn),
    .baseVal(baseVal), .idxEn(idxEn), .idxId(idxId), .idxVal(idxVal),
    .scaleCode(scaleCode), .dispBytes(dispBytes), .dispSize(dispSize),
    .outValid(outValid), .addr(addr), .illegal(illegal)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input bit bE, input logic [31:0] b,
      input bit iE, input logic [31:0] iv, input logic [1:0] sc,
      input logic [1:0] ds, input logic [31:0] d);
    logic [31:0] dv;
    case (ds)
      2'd0: dv = 32'd0;
      2'd1: dv = 32'($signed(d[7:0]));
      2'd2: dv = 32'($signed(d[15:0]));
      default: dv = d;
    endcase
    return (bE ? b : 32'd0) + (iE ? iv * (32'd1 << sc) : 32'd0) + dv;
  endfunction

  task automatic issue(input bit bE, input logic [31:0] b, input bit iE,
      input logic [3:0] id, input logic [31:0] iv, input logic [1:0] sc,
      input logic [1:0] ds, input logic [31:0] d);
    @(negedge clk);
    baseEn = bE; baseVal = b; idxEn = iE; idxId = id; idxVal = iv;
    scaleCode = sc; dispSize = ds; dispBytes = d; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL R8 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] bv [3];
    logic [31:0] iv [3];
    logic [31:0] dv [3];
    logic [31:0] e;
    bv[0] = 32'h0000_f000; iv[0] = 32'h0000_0100; dv[0] = 32'h0000_0008;
    bv[1] = 32'h1234_5678; iv[1] = 32'h0000_0abc; dv[1] = 32'h7f80_fe90;
    bv[2] = 32'hffff_ff00; iv[2] = 32'hc000_0001; dv[2] = 32'h8000_8081;

    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R9 outValid in reset", {31'd0, outValid}, 32'd0);
    check(addr === 32'd0, "R9 addr in reset", addr, 32'd0);
    check(illegal === 1'b0, "R9 illegal in reset", {31'd0, illegal}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 3; v++)
      for (int sc = 0; sc < 4; sc++)
        for (int ds = 0; ds < 4; ds++)
          for (int be = 0; be < 2; be++)
            for (int ie = 0; ie < 2; ie++)
              for (int id = 0; id < 8; id++) begin
                bit bad;
                issue(be[0], bv[v], ie[0], id[3:0], iv[v], sc[1:0], ds[1:0], dv[v]);
                bad = ie[0] && (id == 4);
                e = bad ? 32'd0 : model(be[0], bv[v], ie[0], iv[v], sc[1:0], ds[1:0], dv[v]);
                check(outValid === 1'b1, "R8 sweep outValid", {31'd0, outValid}, 32'd1);
                check(illegal === bad, bad ? "R6 sweep flag" : "R1 sweep flag",
                      {31'd0, illegal}, {31'd0, bad});
                check(addr === e, bad ? "R6 sweep addr" : "R1 sweep addr", addr, e);
              end

    issue(1, 32'hf000, 1, 4'd2, 32'h100, 2'd0, 2'd0, 0);
    check(addr === 32'hf100, "R1 base+index scale 1", addr, 32'hf100);
    issue(1, 32'hf000, 1, 4'd2, 32'h100, 2'd2, 2'd0, 0);
    check(addr === 32'hf400, "R2 scale 4", addr, 32'hf400);
    issue(1, 32'hf000, 1, 4'd2, 32'h100, 2'd3, 2'd0, 0);
    check(addr === 32'hf800, "R2 scale 8", addr, 32'hf800);
    issue(1, 32'hf000, 0, 4'd0, 0, 2'd0, 2'd1, 32'h08);
    check(addr === 32'hf008, "R3 byte disp", addr, 32'hf008);
    issue(1, 32'h100, 0, 4'd0, 0, 2'd0, 2'd1, 32'h55aa_12f4);
    check(addr === 32'h0f4, "R3 byte disp sign-extended", addr, 32'h0f4);
    issue(1, 32'h10000, 0, 4'd0, 0, 2'd0, 2'd2, 32'h0000_fffe);
    check(addr === 32'hfffe, "R3 halfword disp sign-extended", addr, 32'hfffe);
    issue(0, 32'hdead_beef, 1, 4'd2, 32'hf000, 2'd1, 2'd3, 32'h80);
    check(addr === 32'h1e080, "R4 no base", addr, 32'h1e080);
    issue(1, 32'h40, 0, 4'd4, 32'hffff, 2'd3, 2'd0, 0);
    check(addr === 32'h40 && illegal === 1'b0, "R5 index off ignores ID 4", addr, 32'h40);
    issue(1, 32'h40, 1, 4'd4, 32'h10, 2'd0, 2'd0, 0);
    check(illegal === 1'b1 && addr === 32'd0, "R6 stack pointer index", addr, 32'd0);
    issue(1, 32'hffff_fff0, 0, 4'd0, 0, 2'd0, 2'd3, 32'h20);
    check(addr === 32'h10, "R7 wrap", addr, 32'h10);

    @(negedge clk);
    baseVal = 32'h1111_1111; dispBytes = 32'h2222; dispSize = 2'd3; baseEn = 1'b1;
    idxEn = 1'b1; idxId = 4'd4;
    @(negedge clk);
    check(outValid === 1'b0, "R8 outValid idle", {31'd0, outValid}, 32'd0);
    check(addr === 32'h10 && illegal === 1'b0, "R8 hold while idle", addr, 32'h10);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule